// File: doc/BRIEF.md
# Pipelined Right-to-Left Modular Exponentiator

This block raises a base to an exponent modulo a modulus, `base^exponent mod modulus`, by the right-to-left binary method. A single modular multiplier is cut into two half-length stages. The first stage forms a full-width product, or passes its first operand through unchanged when the control bit is clear. The second stage reduces that value modulo the modulus. One buffer register sits between the two stages. On every clock one first-stage operation and one second-stage operation run at the same time. The squaring chain and the conditional-accumulate chain interleave through the one multiplier.

The datapath keeps three operand registers. `buf_q` is the pipeline buffer. `acc_q` alternately holds the current square and the running accumulator. `sq_q` holds the current square for the two clocks in which it is needed. The controller has four states:
- `ST_IDLE` waits for a job. It moves to `ST_LOAD` when `in_valid` is high.
- `ST_LOAD` reduces the base into `acc_q` and `sq_q`, and seeds the buffer with the pass-through value 1. It moves to `ST_SQUARE`.
- `ST_SQUARE` is the even time step. It issues the squaring of `acc_q` and writes the reduced accumulator into `acc_q`. It moves to `ST_MULT`, or to `ST_IDLE` after the last step.
- `ST_MULT` is the odd time step. It issues the accumulator times the square, gated by the current exponent bit, and writes the reduced new square into both `acc_q` and `sq_q`. It then moves back to `ST_SQUARE`.

Exponent bits are taken least-significant first from a shift register. All `EXP_BITS` bits are always processed, so the latency is fixed.

Top module: `modexp_pipe`

## Requirements
- R1: `in_ready` is 1 exactly while the block is idle. A job is taken at a rising edge where `in_valid` and `in_ready` are both 1. `in_valid` and the data inputs have no effect while `in_ready` is 0.
- R2: For any `modulus` from 1 to 2^WIDTH-1 and any `base`, including `base >= modulus`, `result` equals `base^exponent mod modulus`, with all `EXP_BITS` exponent bits used, least-significant first.
- R3: With `exponent` = 0 the result is 1 mod `modulus`: 1 for a modulus above 1, and 0 for modulus 1.
- R4: With `exponent` = 1 the result is `base mod modulus`.
- R5: `done` rises after rising edge number 2*EXP_BITS+2, counting the accepting edge as edge 0, whatever the exponent value.
- R6: `done` is a one-cycle pulse, and `result` carries the job's answer in that same cycle.
- R7: While `in_ready` is 1, `result` does not change. The last answer is held until a new job is running.
- R8: `in_ready` is 1 in the cycle in which `done` is 1, so the next job can be taken at the following edge.
- R9: During and right after reset, `in_ready` is 1, `done` is 0 and `result` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Job request |
| in_ready | output | 1 | Block is idle and can take a job |
| base | input | WIDTH | Base of the power |
| exponent | input | EXP_BITS | Exponent, consumed LSB first |
| modulus | input | WIDTH | Modulus, must be nonzero |
| result | output | WIDTH | Last computed power |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bench targets these corner cases:
- **Exponent zero.** If the buffer seed were wrong, this case would expose it as a result other than 1, or other than 0 when the modulus is 1.
- **Base not below the modulus.** This catches a base that is never reduced before squaring.
- **All-ones exponent.** This catches a bit order or a step count that is off by one, which would produce wrong powers or a shifted `done`.
- **Back-to-back jobs.** Requests held asserted while busy, with other data on the inputs, show whether the block wrongly takes a second job or corrupts the running one.

A cycle-level model checks `in_ready`, `done` and the held result on every clock.

// File: rtl/modexp_pkg.sv
package modexp_pkg;

    // Controller phases of the two-stage schedule.
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_LOAD   = 2'd1,
        ST_SQUARE = 2'd2,
        ST_MULT   = 2'd3
    } phase_t;

endpackage

// File: rtl/modexp_f1.sv
// First pipeline stage: full-width product, or pass-through of the first
// operand when the control bit is clear.
module modexp_f1 #(
    parameter int WIDTH = 16
) (
    input  logic [WIDTH-1:0]   op_a,
    input  logic [WIDTH-1:0]   op_b,
    input  logic               use_b,
    output logic [2*WIDTH-1:0] prod
);
    localparam int PW = 2 * WIDTH;

    always_comb begin
        if (use_b) begin
            prod = PW'(op_a) * PW'(op_b);
        end else begin
            prod = PW'(op_a);
        end
    end

endmodule

// File: rtl/modexp_f2.sv
// Second pipeline stage: reduction of a double-width value modulo m by
// bit-serial restoring remainder, unrolled into combinational logic.
module modexp_f2 #(
    parameter int WIDTH = 16
) (
    input  logic [2*WIDTH-1:0] value,
    input  logic [WIDTH-1:0]   modv,
    output logic [WIDTH-1:0]   rem_out
);
    localparam int PW = 2 * WIDTH;

    logic [WIDTH:0] part;

    always_comb begin
        part = '0;
        for (int k = PW - 1; k >= 0; k--) begin
            part = {part[WIDTH-1:0], value[k]};
            if (part >= {1'b0, modv}) begin
                part = part - {1'b0, modv};
            end
        end
        rem_out = part[WIDTH-1:0];
    end

endmodule

// File: rtl/modexp_ctrl.sv
// Schedule controller: phase sequencing, step count and exponent bits.
module modexp_ctrl
    import modexp_pkg::*;
#(
    parameter int EXP_BITS = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    input  logic [EXP_BITS-1:0] exponent,
    output logic                in_ready,
    output phase_t              phase,
    output logic                ebit,
    output logic                done
);
    localparam int CW = $clog2(EXP_BITS + 1);

    phase_t                phase_q;
    phase_t                phase_d;
    logic [CW-1:0]         step_q;
    logic [EXP_BITS-1:0]   eshift_q;
    logic                  last_step;

    assign last_step = (step_q == CW'(EXP_BITS));

    // Next-state logic.
    always_comb begin
        phase_d = phase_q;
        unique case (phase_q)
            ST_IDLE:   if (in_valid) phase_d = ST_LOAD;
            ST_LOAD:   phase_d = ST_SQUARE;
            ST_SQUARE: phase_d = last_step ? ST_IDLE : ST_MULT;
            ST_MULT:   phase_d = ST_SQUARE;
            default:   phase_d = ST_IDLE;
        endcase
    end

    // State register with step counter and exponent shifter.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase_q  <= ST_IDLE;
            step_q   <= '0;
            eshift_q <= '0;
        end else begin
            phase_q <= phase_d;
            unique case (phase_q)
                ST_IDLE: if (in_valid) eshift_q <= exponent;
                ST_LOAD: step_q <= '0;
                ST_MULT: begin
                    step_q   <= step_q + CW'(1);
                    eshift_q <= eshift_q >> 1;
                end
                default: ;
            endcase
        end
    end

    // Output process.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done <= 1'b0;
        end else begin
            done <= (phase_q == ST_SQUARE) && last_step;
        end
    end

    assign in_ready = (phase_q == ST_IDLE);
    assign phase    = phase_q;
    assign ebit     = eshift_q[0];

    AST_MULT_THEN_SQUARE: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == ST_MULT) |=> (phase_q == ST_SQUARE)); // R5
    AST_STEP_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        step_q <= CW'(EXP_BITS)); // R5
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R6
    AST_DONE_READY: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> in_ready); // R8

endmodule

// File: rtl/modexp_pipe.sv
// Top: three operand registers around a two-stage modular multiplier.
module modexp_pipe
    import modexp_pkg::*;
#(
    parameter int WIDTH    = 16,
    parameter int EXP_BITS = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    output logic                in_ready,
    input  logic [WIDTH-1:0]    base,
    input  logic [EXP_BITS-1:0] exponent,
    input  logic [WIDTH-1:0]    modulus,
    output logic [WIDTH-1:0]    result,
    output logic                done
);
    localparam int PW = 2 * WIDTH;

    phase_t           phase;
    logic             ebit;
    logic [PW-1:0]    buf_q;
    logic [WIDTH-1:0] acc_q;
    logic [WIDTH-1:0] sq_q;
    logic [WIDTH-1:0] mod_q;
    logic [WIDTH-1:0] opa;
    logic [WIDTH-1:0] opb;
    logic             use_b;
    logic [PW-1:0]    f1_out;
    logic [WIDTH-1:0] red;

    modexp_ctrl #(.EXP_BITS(EXP_BITS)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .exponent (exponent),
        .in_ready (in_ready),
        .phase    (phase),
        .ebit     (ebit),
        .done     (done)
    );

    // Stage-one operand steering per phase.
    always_comb begin
        opa   = acc_q;
        opb   = sq_q;
        use_b = 1'b0;
        unique case (phase)
            ST_LOAD:   begin opa = WIDTH'(1); use_b = 1'b0; end
            ST_SQUARE: begin opb = acc_q;     use_b = 1'b1; end
            ST_MULT:   begin opb = sq_q;      use_b = ebit; end
            default:   ;
        endcase
    end

    modexp_f1 #(.WIDTH(WIDTH)) u_f1 (
        .op_a  (opa),
        .op_b  (opb),
        .use_b (use_b),
        .prod  (f1_out)
    );

    modexp_f2 #(.WIDTH(WIDTH)) u_f2 (
        .value   (buf_q),
        .modv    (mod_q),
        .rem_out (red)
    );

    // Operand registers.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            buf_q <= '0;
            acc_q <= '0;
            sq_q  <= '0;
            mod_q <= '0;
        end else begin
            unique case (phase)
                ST_IDLE: if (in_valid) begin
                    buf_q <= PW'(base);
                    mod_q <= modulus;
                end
                ST_LOAD: begin
                    acc_q <= red;
                    sq_q  <= red;
                    buf_q <= f1_out;
                end
                ST_SQUARE: begin
                    acc_q <= red;
                    buf_q <= f1_out;
                end
                ST_MULT: begin
                    acc_q <= red;
                    sq_q  <= red;
                    buf_q <= f1_out;
                end
                default: ;
            endcase
        end
    end

    assign result = acc_q;

    AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |=> $stable(result)); // R7
    AST_RED_BELOW_MOD: assert property (@(posedge clk) disable iff (!rst_n)
        (phase != ST_IDLE) |-> (red < mod_q)); // R2
    AST_MOD_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |-> (modulus != '0)); // R2
    AST_LOAD_AFTER_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> !in_ready); // R1

endmodule

// File: tb/tb_modexp_pipe.sv
module tb_modexp_pipe;
    localparam int WIDTH    = 16;
    localparam int EXP_BITS = 16;
    localparam int LAT      = 2 * EXP_BITS + 2;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic                in_valid = 1'b0;
    logic                in_ready;
    logic [WIDTH-1:0]    base = '0;
    logic [EXP_BITS-1:0] exponent = '0;
    logic [WIDTH-1:0]    modulus = 16'd1;
    logic [WIDTH-1:0]    result;
    logic                done;

    int checks = 0;
    int errors = 0;
    bit reported = 0;

    always #10 clk = ~clk;

    modexp_pipe #(.WIDTH(WIDTH), .EXP_BITS(EXP_BITS)) dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .base(base), .exponent(exponent), .modulus(modulus),
        .result(result), .done(done)
    );

    function automatic longint unsigned ref_pow(longint unsigned b,
                                                longint unsigned e,
                                                longint unsigned m);
        longint unsigned x = 1 % m;
        longint unsigned y = b % m;
        for (int i = 0; i < EXP_BITS; i++) begin
            if (e[i]) x = (x * y) % m;
            y = (y * y) % m;
        end
        return x;
    endfunction

    // Behavioural cycle model.
    bit              busy_m = 0;
    bit              done_m = 0;
    bit              have_res = 0;
    int              cnt_m = 0;
    longint unsigned ans_m = 0;
    longint unsigned res_m = 0;
    string           tag_in = "R2";
    string           tag_job = "R2";
    string           tag_done = "R2";

    always @(posedge clk) begin
        if (!rst_n) begin
            busy_m = 0; done_m = 0; have_res = 0; cnt_m = 0;
        end else begin
            bit take;
            take = in_valid && !busy_m;
            done_m = 0;
            if (busy_m) begin
                cnt_m++;
                if (cnt_m == LAT) begin
                    done_m = 1; busy_m = 0; res_m = ans_m;
                    have_res = 1; tag_done = tag_job;
                end
            end
            if (take) begin
                busy_m = 1; cnt_m = 0;
                ans_m = ref_pow(base, exponent, modulus);
                tag_job = tag_in;
            end
        end
    end

    task automatic check(string req, longint unsigned act, longint unsigned exp_v);
        checks++;
        if (act != exp_v) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp_v, $time);
        end
    endtask

    // Per-cycle comparison away from the active edge.
    always @(negedge clk) begin
        if (rst_n && !reported) begin
            check("R1", in_ready, !busy_m);
            check("R5", done, done_m);
            if (done_m) begin
                check("R6", result, res_m);
                check(tag_done, result, res_m);
                check("R8", in_ready, 1);
            end else if (!busy_m && have_res) begin
                check("R7", result, res_m);
            end
        end
    end

    task automatic report();
        if (!reported) begin
            reported = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    task automatic send(input logic [WIDTH-1:0] b, input logic [EXP_BITS-1:0] e,
                        input logic [WIDTH-1:0] m, input string tag);
        @(negedge clk);
        while (!in_ready) @(negedge clk);
        in_valid = 1'b1; base = b; exponent = e; modulus = m; tag_in = tag;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic wait_idle();
        @(negedge clk);
        while (busy_m) @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        report();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R9: reset state
        check("R9", in_ready, 1);
        check("R9", done, 0);
        check("R9", result, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R9", result, 0);

        send(16'd1234, 16'd0, 16'd1000, "R3"); wait_idle();
        send(16'd77, 16'd0, 16'd1, "R3"); wait_idle();
        send(16'd4321, 16'd1, 16'd999, "R4"); wait_idle();
        send(16'd50000, 16'd1, 16'd7, "R4"); wait_idle();
        send(16'd60000, 16'hFFFF, 16'd65521, "R2"); wait_idle();
        send(16'd0, 16'd5, 16'd13, "R2"); wait_idle();
        send(16'd3, 16'd200, 16'd1, "R2"); wait_idle();
        send(16'hFFFF, 16'h8001, 16'hFFFF, "R2"); wait_idle();

        // R1: requests while busy are ignored (other data on the inputs).
        send(16'd5, 16'd117, 16'd1009, "R1");
        in_valid = 1'b1; base = 16'd9; exponent = 16'd3; modulus = 16'd11;
        repeat (20) @(negedge clk);
        in_valid = 1'b0;
        wait_idle();

        // R8: back-to-back jobs, next taken right after done.
        for (int j = 0; j < 4; j++) begin
            send(16'(100 + j), 16'(j * 37 + 1), 16'(5000 + j), "R8");
        end
        wait_idle();

        for (int j = 0; j < 30; j++) begin
            send(16'($urandom), 16'($urandom), 16'($urandom_range(1, 65535)), "R2");
        end
        wait_idle();
        repeat (5) @(negedge clk);
        report();
    end

endmodule